// File: doc/BRIEF.md
# Session Key Vault and Cipher Sequencer

This block is the control and key-holding core of a security module that sits beside a host processor. It keeps three secret keys: a master key used to unwrap session keys, a master key used to fingerprint them, and the current session key. The host runs the block by issuing 4-bit instruction codes together with a 128-bit data word. The block then sequences one operation on an external block-cipher engine over a request/done handshake. The engine receives a data operand and a key operand on separate buses, plus a direction flag.

The key operand is driven only from the internal key registers. New session key material is written only from the engine's result. A session key reaches the vault by one of two routes. The host can supply a wrapped key, which is deciphered under the unwrap master key. Or a fixed-width random word can be used, which is also deciphered before it is stored. The host authenticates the session key by handing in an expected fingerprint. The block enciphers the session key under the fingerprint master key and compares the two values. Only after a match will the block encrypt host data under the session key. No deciphered value is ever placed on the host data output, so ciphertext-to-plaintext decryption of host data is not available.

Master keys enter on a dedicated key input while the block is idle. A 4-bit status word reports busy, done, fingerprint match and rejected-instruction conditions.

Top module: `keyvault_ctrl`

## Requirements
- R1: After reset, status is 0 (bit0 busy, bit1 done, bit2 match, bit3 illegal), host_dout is 0 and eng_req is 0.
- R2: mk_load with mk_sel=0 stores mk_data as the unwrap master key, and with mk_sel=1 as the fingerprint master key. The unwrap key is the engine key for codes 1 and 2, and the fingerprint key is the engine key for code 3.
- R3: Code 1 (load session key) asks the engine to decipher host_din (eng_decrypt=1) under the unwrap master key. The result becomes the session key, and host_dout is left unchanged.
- R4: Code 2 (generate session key) deciphers rng_word under the unwrap master key into the session key, and copies rng_word to host_dout.
- R5: Code 3 (authenticate) enciphers the session key (eng_data) under the fingerprint master key. The result goes to host_dout, and status bit2 becomes 1 exactly when the result equals host_din.
- R6: Code 4 (encrypt) enciphers host_din under the session key and returns the result on host_dout. It is accepted only while status bit2 is 1.
- R7: An accepted code 1 or code 2 clears status bit2.
- R8: An unknown code (0, or 5 to 15), or an operation whose key is not loaded or whose condition is not met, sets status bit3. It issues no engine request and leaves host_dout, the keys and bit2 unchanged.
- R9: From acceptance until the engine's done, status bit0 is 1 and eng_req is held. While bit0 is 1, instructions and mk_load are ignored.
- R10: Done (bit1) rises on completion and holds until the next accepted instruction. Any accepted instruction clears bit1 and bit3.
- R11: host_dout changes only on completion of an enciphering operation or on acceptance of code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mk_load | input | 1 | Master key write strobe |
| mk_sel | input | 1 | 0: unwrap master key, 1: fingerprint master key |
| mk_data | input | 128 | Master key value |
| instr_valid | input | 1 | Instruction strobe |
| instr_code | input | 4 | Instruction code |
| host_din | input | 128 | Host data / wrapped key / expected fingerprint |
| rng_word | input | 128 | Random word for key generation |
| host_dout | output | 128 | Result register toward host |
| status | output | 4 | {illegal, match, done, busy} |
| eng_req | output | 1 | Engine request, held until done |
| eng_decrypt | output | 1 | 1: decipher, 0: encipher |
| eng_data | output | 128 | Engine data operand |
| eng_key | output | 128 | Engine key operand |
| eng_done | input | 1 | Engine completion pulse |
| eng_result | input | 128 | Engine result |

## Verification
Two events can meet in one cycle: a new instruction strobe or master key write, and the block's own busy window. The bench provokes this by pulsing a load-session instruction and a master key write while an encrypt is in flight. It then judges the outcome through later operations: the encrypt result must be intact, the old session key must still authenticate, and the engine key for the next unwrap must be the old master key. The second collision is between an accepted instruction and a pending done flag. The bench holds done for several idle cycles and then confirms that acceptance alone clears it.

// File: rtl/keyvault_pkg.sv
package keyvault_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [3:0] {
        OP_NONE     = 4'd0,
        OP_LOAD_SK  = 4'd1,
        OP_GEN_SK   = 4'd2,
        OP_AUTH     = 4'd3,
        OP_ENCRYPT  = 4'd4
    } op_e;

    typedef enum logic [1:0] {
        KS_NONE  = 2'd0,
        KS_UNWRAP = 2'd1,
        KS_FPRINT = 2'd2,
        KS_SESS  = 2'd3
    } ksel_e;

    typedef enum logic {
        DS_OPND = 1'b0,
        DS_SESS = 1'b1
    } dsel_e;

    typedef struct packed {
        logic  illegal;
        logic  match;
        logic  done;
        logic  busy;
    } status_t;

    typedef struct packed {
        logic  legal;
        op_e   op;
        logic  decrypt;
        ksel_e ksel;
        dsel_e dsel;
    } dec_t;

    function automatic dec_t decode_op(logic [CODE_W-1:0] code,
                                       logic unwrap_v, logic fprint_v,
                                       logic sess_v, logic authed);
        dec_t d;
        d = '{legal: 1'b0, op: OP_NONE, decrypt: 1'b0, ksel: KS_NONE, dsel: DS_OPND};
        case (code)
            4'd1: d = '{legal: unwrap_v, op: OP_LOAD_SK, decrypt: 1'b1,
                        ksel: KS_UNWRAP, dsel: DS_OPND};
            4'd2: d = '{legal: unwrap_v, op: OP_GEN_SK, decrypt: 1'b1,
                        ksel: KS_UNWRAP, dsel: DS_OPND};
            4'd3: d = '{legal: fprint_v && sess_v, op: OP_AUTH, decrypt: 1'b0,
                        ksel: KS_FPRINT, dsel: DS_SESS};
            4'd4: d = '{legal: sess_v && authed, op: OP_ENCRYPT, decrypt: 1'b0,
                        ksel: KS_SESS, dsel: DS_OPND};
            default: d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/kv_key_store.sv
module kv_key_store
    import keyvault_pkg::*;
#(
    parameter int KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mk_we,
    input  logic             mk_sel,
    input  logic [KEY_W-1:0] mk_wdata,
    input  logic             sk_we,
    input  logic [KEY_W-1:0] sk_wdata,
    input  logic             key_en,
    input  ksel_e            ksel,
    output logic [KEY_W-1:0] key_bus,
    output logic [KEY_W-1:0] sess_bus,
    output logic             unwrap_v,
    output logic             fprint_v,
    output logic             sess_v
);
    logic [KEY_W-1:0] unwrap_q, fprint_q, sess_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            unwrap_q <= '0;
            fprint_q <= '0;
            sess_q   <= '0;
            unwrap_v <= 1'b0;
            fprint_v <= 1'b0;
            sess_v   <= 1'b0;
        end else begin
            if (mk_we && !mk_sel) begin
                unwrap_q <= mk_wdata;
                unwrap_v <= 1'b1;
            end
            if (mk_we && mk_sel) begin
                fprint_q <= mk_wdata;
                fprint_v <= 1'b1;
            end
            if (sk_we) begin
                sess_q <= sk_wdata;
                sess_v <= 1'b1;
            end
        end
    end

    // Key operand is driven only while a request is live; no selection
    // outside the loaded keys is ever requested by the sequencer.
    always_comb begin
        key_bus = '0;
        if (key_en) begin
            case (ksel)
                KS_UNWRAP: key_bus = unwrap_q;
                KS_FPRINT: key_bus = fprint_q;
                KS_SESS:   key_bus = sess_q;
                default:   key_bus = '0;
            endcase
        end
    end

    assign sess_bus = sess_q;

endmodule

// File: rtl/kv_fp_cmp.sv
module kv_fp_cmp #(
    parameter int W = 128
) (
    input  logic [W-1:0] computed,
    input  logic [W-1:0] expected,
    output logic         equal
);
    assign equal = (computed == expected);
endmodule

// File: rtl/kv_seq.sv
module kv_seq
    import keyvault_pkg::*;
#(
    parameter int W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [CODE_W-1:0] instr_code,
    input  logic [W-1:0]      host_din,
    input  logic [W-1:0]      rng_word,
    input  logic              unwrap_v,
    input  logic              fprint_v,
    input  logic              sess_v,
    input  logic              eng_done,
    input  logic [W-1:0]      eng_result,
    input  logic              fp_equal,
    output logic              run,
    output logic              dec_mode,
    output ksel_e             ksel,
    output dsel_e             dsel,
    output logic [W-1:0]      opnd,
    output logic              sk_we,
    output logic [W-1:0]      host_dout,
    output status_t           status
);
    op_e   op_q;
    logic  done_q, match_q, illegal_q;
    logic  accept;
    dec_t  dec;

    assign accept = instr_valid && !run;
    assign dec    = decode_op(instr_code, unwrap_v, fprint_v, sess_v, match_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            op_q      <= OP_NONE;
            dec_mode  <= 1'b0;
            ksel      <= KS_NONE;
            dsel      <= DS_OPND;
            opnd      <= '0;
            host_dout <= '0;
            done_q    <= 1'b0;
            match_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else if (accept) begin
            done_q    <= 1'b0;
            illegal_q <= !dec.legal;
            if (dec.legal) begin
                run      <= 1'b1;
                op_q     <= dec.op;
                dec_mode <= dec.decrypt;
                ksel     <= dec.ksel;
                dsel     <= dec.dsel;
                opnd     <= (dec.op == OP_GEN_SK) ? rng_word : host_din;
                if (dec.op == OP_GEN_SK)
                    host_dout <= rng_word;
                if (dec.op == OP_LOAD_SK || dec.op == OP_GEN_SK)
                    match_q <= 1'b0;
            end
        end else if (run && eng_done) begin
            run    <= 1'b0;
            done_q <= 1'b1;
            ksel   <= KS_NONE;
            if (!dec_mode)
                host_dout <= eng_result;
            if (op_q == OP_AUTH)
                match_q <= fp_equal;
        end
    end

    assign sk_we  = run && eng_done && dec_mode;
    assign status = '{illegal: illegal_q, match: match_q, done: done_q, busy: run};

endmodule

// File: rtl/keyvault_ctrl.sv
module keyvault_ctrl
    import keyvault_pkg::*;
#(
    parameter int W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mk_load,
    input  logic              mk_sel,
    input  logic [W-1:0]      mk_data,
    input  logic              instr_valid,
    input  logic [CODE_W-1:0] instr_code,
    input  logic [W-1:0]      host_din,
    input  logic [W-1:0]      rng_word,
    output logic [W-1:0]      host_dout,
    output logic [3:0]        status,
    output logic              eng_req,
    output logic              eng_decrypt,
    output logic [W-1:0]      eng_data,
    output logic [W-1:0]      eng_key,
    input  logic              eng_done,
    input  logic [W-1:0]      eng_result
);
    logic        run, dec_mode, sk_we, fp_equal;
    logic        unwrap_v, fprint_v, sess_v;
    ksel_e       ksel;
    dsel_e       dsel;
    logic [W-1:0] opnd, sess_bus;
    status_t     st;

    kv_seq #(.W(W)) u_seq (
        .clk(clk), .rst(rst),
        .instr_valid(instr_valid), .instr_code(instr_code),
        .host_din(host_din), .rng_word(rng_word),
        .unwrap_v(unwrap_v), .fprint_v(fprint_v), .sess_v(sess_v),
        .eng_done(eng_done), .eng_result(eng_result), .fp_equal(fp_equal),
        .run(run), .dec_mode(dec_mode), .ksel(ksel), .dsel(dsel),
        .opnd(opnd), .sk_we(sk_we), .host_dout(host_dout), .status(st)
    );

    kv_key_store #(.KEY_W(W)) u_keys (
        .clk(clk), .rst(rst),
        .mk_we(mk_load && !run), .mk_sel(mk_sel), .mk_wdata(mk_data),
        .sk_we(sk_we), .sk_wdata(eng_result),
        .key_en(run), .ksel(ksel),
        .key_bus(eng_key), .sess_bus(sess_bus),
        .unwrap_v(unwrap_v), .fprint_v(fprint_v), .sess_v(sess_v)
    );

    kv_fp_cmp #(.W(W)) u_cmp (
        .computed(eng_result), .expected(opnd), .equal(fp_equal)
    );

    assign eng_req     = run;
    assign eng_decrypt = run && dec_mode;
    assign eng_data    = !run ? '0 : ((dsel == DS_SESS) ? sess_bus : opnd);
    assign status      = st;

endmodule

// File: rtl/keyvault_ctrl_chk.sv
module keyvault_ctrl_chk
    import keyvault_pkg::*;
#(
    parameter int W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [CODE_W-1:0] instr_code,
    input logic [W-1:0]      host_dout,
    input logic [3:0]        status,
    input logic              eng_req,
    input logic              eng_decrypt,
    input logic              eng_done
);
    // R9
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        eng_req |-> status[0]);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_done) |=> eng_req);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (status[1] && !(instr_valid && !status[0])) |=> status[1]);

    // R10
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[1]) |-> $past(eng_done));

    // R8
    illegal_idle_chk: assert property (@(posedge clk) disable iff (rst)
        status[3] |-> !eng_req);

    // R11
    dout_src_chk: assert property (@(posedge clk) disable iff (rst)
        (host_dout != $past(host_dout)) |->
            (($past(eng_done) && $past(eng_req) && !$past(eng_decrypt)) ||
             ($past(instr_valid) && !$past(status[0]) &&
              $past(instr_code) == 4'd2)));

    // R5
    match_src_chk: assert property (@(posedge clk) disable iff (rst)
        (status[2] != $past(status[2])) |->
            ($past(eng_done) || ($past(instr_valid) && !$past(status[0]))));
endmodule

bind keyvault_ctrl keyvault_ctrl_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_code(instr_code),
    .host_dout(host_dout), .status(status), .eng_req(eng_req),
    .eng_decrypt(eng_decrypt), .eng_done(eng_done)
);

// File: tb/keyvault_ctrl_tb.sv
module keyvault_ctrl_tb;
    localparam int W = 128;
    localparam int LAT = 3;
    localparam logic [W-1:0] RNG = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

    logic clk = 0, rst = 1;
    logic mk_load = 0, mk_sel = 0, instr_valid = 0;
    logic [W-1:0] mk_data = '0, host_din = '0, rng_word = RNG;
    logic [3:0] instr_code = '0;
    logic [W-1:0] host_dout, eng_data, eng_key, eng_result;
    logic [3:0] status;
    logic eng_req, eng_decrypt, eng_done;

    int checks = 0, failures = 0, req_cnt = 0, cyc = 0;
    logic [W-1:0] last_key, last_data;
    logic last_dec;
    int eng_cnt = 0;

    always #5 clk = ~clk;

    keyvault_ctrl #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .mk_load(mk_load), .mk_sel(mk_sel), .mk_data(mk_data),
        .instr_valid(instr_valid), .instr_code(instr_code), .host_din(host_din),
        .rng_word(rng_word), .host_dout(host_dout), .status(status),
        .eng_req(eng_req), .eng_decrypt(eng_decrypt), .eng_data(eng_data),
        .eng_key(eng_key), .eng_done(eng_done), .eng_result(eng_result)
    );

    function automatic logic [W-1:0] f_enc(logic [W-1:0] d, logic [W-1:0] k);
        logic [W-1:0] x;
        x = d ^ k;
        return {x[W-14:0], x[W-1:W-13]};
    endfunction

    function automatic logic [W-1:0] f_dec(logic [W-1:0] c, logic [W-1:0] k);
        return {c[12:0], c[W-1:13]} ^ k;
    endfunction

    // stand-in engine
    always @(posedge clk) begin
        if (rst) begin
            eng_done <= 0; eng_result <= '0; eng_cnt <= 0;
        end else if (eng_done) begin
            eng_done <= 0;
        end else if (eng_req) begin
            if (eng_cnt == LAT - 1) begin
                eng_cnt    <= 0;
                eng_done   <= 1;
                eng_result <= eng_decrypt ? f_dec(eng_data, eng_key) : f_enc(eng_data, eng_key);
                last_key   <= eng_key;
                last_data  <= eng_data;
                last_dec   <= eng_decrypt;
                req_cnt    <= req_cnt + 1;
            end else eng_cnt <= eng_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish (actual cycle %0d, expected < 100000)", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic [3:0] code, logic [W-1:0] din);
        @(negedge clk);
        instr_valid = 1; instr_code = code; host_din = din;
        @(negedge clk);
        instr_valid = 0;
        while (status[0]) @(negedge clk);
    endtask

    task automatic load_mk(logic sel, logic [W-1:0] k);
        @(negedge clk);
        mk_load = 1; mk_sel = sel; mk_data = k;
        @(negedge clk);
        mk_load = 0;
    endtask

    logic [W-1:0] mke, mka, sk, fp, prev, pt;
    int rq;

    initial begin
        mke = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        mka = 128'hA5A5A5A5_5A5A5A5A_01234567_89ABCDEF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk("R1 status", {124'd0, status}, '0);
        chk("R1 dout", host_dout, '0);
        chk("R1 req", {127'd0, eng_req}, '0);

        // R8: unwrap before master key loaded
        rq = req_cnt;
        issue(4'd1, 128'h55);
        chk("R8 no key illegal", {127'd0, status[3]}, 1);
        chk("R8 no request", rq, req_cnt);

        load_mk(0, mke);
        load_mk(1, mka);

        // R8: encrypt before authentication / no session key
        issue(4'd4, 128'h77);
        chk("R6 enc without auth", {127'd0, status[3]}, 1);

        // R3 / R2
        issue(4'd1, 128'hDEADBEEF_00000000_CAFEF00D_12345678);
        sk = f_dec(128'hDEADBEEF_00000000_CAFEF00D_12345678, mke);
        chk("R2 unwrap key", last_key, mke);
        chk("R3 decipher mode", {127'd0, last_dec}, 1);
        chk("R3 dout unchanged", host_dout, '0);
        chk("R10 done", {124'd0, status}, 4'b0010);

        // R5 wrong fingerprint
        fp = f_enc(sk, mka);
        issue(4'd3, fp ^ 128'h1);
        chk("R5 fp out", host_dout, fp);
        chk("R2 fprint key", last_key, mka);
        chk("R5 sess as data", last_data, sk);
        chk("R5 mismatch", {127'd0, status[2]}, 0);
        issue(4'd4, 128'h99);
        chk("R6 refused after mismatch", {127'd0, status[3]}, 1);
        chk("R8 dout kept", host_dout, fp);
        issue(4'd3, fp);
        chk("R5 match", {127'd0, status[2]}, 1);

        // R8 sweep of unknown codes
        for (int c = 0; c < 16; c++) begin
            if (c >= 1 && c <= 4) continue;
            prev = host_dout; rq = req_cnt;
            issue(c[3:0], 128'hF0F0);
            chk($sformatf("R8 code %0d illegal", c), {127'd0, status[3]}, 1);
            chk("R8 dout unchanged", host_dout, prev);
            chk("R8 match kept", {127'd0, status[2]}, 1);
            chk("R8 no request", rq, req_cnt);
        end

        // R6 encryption sweep
        for (int i = 0; i < 8; i++) begin
            pt = {4{32'h9E3779B9 * (i + 1)}};
            issue(4'd4, pt);
            chk($sformatf("R6 encrypt %0d", i), host_dout, f_enc(pt, sk));
            chk("R10 clears illegal", {127'd0, status[3]}, 0);
        end
        chk("R6 key is session", last_key, sk);

        // R9: collision with busy
        pt = 128'h13579BDF;
        @(negedge clk);
        instr_valid = 1; instr_code = 4'd4; host_din = pt;
        @(negedge clk);
        instr_valid = 0;
        chk("R9 busy", {127'd0, status[0]}, 1);
        instr_valid = 1; instr_code = 4'd1; host_din = 128'h1;
        mk_load = 1; mk_sel = 0; mk_data = 128'hBAD;
        @(negedge clk);
        instr_valid = 0; mk_load = 0;
        while (status[0]) @(negedge clk);
        chk("R9 enc intact", host_dout, f_enc(pt, sk));
        issue(4'd3, f_enc(sk, mka));
        chk("R9 session unchanged", {127'd0, status[2]}, 1);

        // R10: done held
        repeat (5) @(negedge clk);
        chk("R10 done held", {127'd0, status[1]}, 1);
        issue(4'd9, '0);
        chk("R10 done cleared", {126'd0, status[3], status[1]}, 2'b10);

        // R4 / R7
        issue(4'd2, 128'h0);
        sk = f_dec(RNG, mke);
        chk("R4 dout rng", host_dout, RNG);
        chk("R9 mk write ignored while busy", last_key, mke);
        chk("R7 match cleared", {127'd0, status[2]}, 0);
        issue(4'd3, f_enc(sk, mka));
        chk("R4 generated key authenticates", {127'd0, status[2]}, 1);
        issue(4'd1, 128'h42);
        chk("R7 load clears match", {127'd0, status[2]}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule